// File: doc/BRIEF.md
# Multithreaded Fetch Slot Thread Picker

This block decides which hardware thread owns the next fetch slot in a multithreaded instruction front end. Every cycle it looks at each thread's fetch state code, whether the thread is active, and how full that thread's issue queue and load/store queue are. A static policy input chooses how the winner is found. The winner's index and a valid flag come out of a register one cycle later.

Three selection schemes are built in. The first walks a stored priority order: the winner moves to the back of that order. The second favours the thread with the emptiest issue queue. The third favours the thread with the emptiest load/store queue. A fourth, single-thread setting looks at the lowest-numbered active thread and nothing else. The stored order tracks deactivation: a thread that goes inactive stops competing. When it comes back, it rejoins behind every thread already in the order.

Top module: `fts_thread_sel`

## Requirements
- R1: A thread is a candidate only when its active bit is 1 and its 3-bit state code is 0 (running), 1 (line fill complete) or 2 (idle). Codes 3 to 7 never win.
- R2: Outputs are registered. The choice made from the inputs present at a rising clock edge appears on `sel_vld`/`sel_tid` just after that edge.
- R3: While `rst` is high at a clock edge, `sel_vld` becomes 0 and the rotating order becomes thread 0, 1, ..., N-1 (head first).
- R4: With policy code 0, the order is scanned from its head and the first candidate wins. The winner moves to the tail, and all other entries keep their relative order.
- R5: With policy code 1, the candidate with the smallest issue-queue count wins. On equal counts, the lower thread index wins.
- R6: With policy code 2, the candidate with the smallest load/store-queue count wins. On equal counts, the lower thread index wins.
- R7: With policy code 3, only the lowest-index active thread is considered, and it wins only if it is a candidate. This code requires at most one active thread.
- R8: When no thread is a candidate, including when no thread is active, `sel_vld` is 0.
- R9: A thread whose active bit rises is placed at the tail of the rotating order before that cycle's scan.
- R10: A win under policy codes 1, 2 or 3 leaves the rotating order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Selection scheme: 0 rotate, 1 issue queue, 2 load/store queue, 3 single thread |
| thr_state | input | 3*N | Fetch state code per thread, thread i at bits [3i+2:3i] |
| thr_active | input | N | Per-thread active bit |
| iq_occ | input | CW*N | Issue-queue count per thread, thread i at bits [CW*i +: CW] |
| lsq_occ | input | CW*N | Load/store-queue count per thread, thread i at bits [CW*i +: CW] |
| sel_vld | output | 1 | A thread was chosen |
| sel_tid | output | log2(N) | Index of the chosen thread |

## Verification
The bench targets four weak spots:
- A thread stalled on a miss sits between ready threads. A picker that rotated a pointer instead of moving only the winner would then grant the wrong thread.
- Equal queue counts are presented. A comparison written as less-or-equal would hand the slot to the higher index.
- The policy is switched from the queue-count schemes back to rotation. A design that also reordered on those wins would break the rotation sequence.
- A thread is deactivated and then reactivated. A picker that left the thread in its old place, instead of putting it last, would grant it early.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [1:0] {
    POL_ROTATE = 2'd0,
    POL_IQ     = 2'd1,
    POL_LSQ    = 2'd2,
    POL_SOLO   = 2'd3
  } fts_policy_e;

  localparam int STATE_W = 3;

  // state codes 0..2 may take a fetch slot; 3..7 are waiting or blocked
  localparam logic [STATE_W-1:0] ST_RUNNING  = 3'd0;
  localparam logic [STATE_W-1:0] ST_FILL_OK  = 3'd1;
  localparam logic [STATE_W-1:0] ST_IDLE     = 3'd2;

  function automatic logic state_ok(input logic [STATE_W-1:0] s);
    return (s == ST_RUNNING) || (s == ST_FILL_OK) || (s == ST_IDLE);
  endfunction

endpackage

// File: rtl/fts_elig.sv
module fts_elig import fts_pkg::*; #(
  parameter int N = 4
) (
  input  logic [N*STATE_W-1:0] thr_state,
  input  logic [N-1:0]         thr_active,
  output logic [N-1:0]         cand
);

  for (genvar g = 0; g < N; g++) begin : g_thr
    assign cand[g] = thr_active[g] & state_ok(thr_state[g*STATE_W +: STATE_W]);
  end

endmodule

// File: rtl/fts_min_pick.sv
module fts_min_pick #(
  parameter int N  = 4,
  parameter int CW = 6,
  parameter int TW = 2
) (
  input  logic [N-1:0]    cand,
  input  logic [N*CW-1:0] occ,
  output logic            pick_vld,
  output logic [TW-1:0]   pick_tid
);

  logic [CW-1:0] best;

  // strict compare keeps the lowest index on a tie
  always_comb begin
    pick_vld = 1'b0;
    pick_tid = '0;
    best     = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!pick_vld || occ[i*CW +: CW] < best)) begin
        pick_vld = 1'b1;
        pick_tid = TW'(i);
        best     = occ[i*CW +: CW];
      end
    end
  end

endmodule

// File: rtl/fts_rr_order.sv
module fts_rr_order #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_move,
  input  logic [N-1:0]  cand,
  input  logic [N-1:0]  thr_active,
  output logic          rr_vld,
  output logic [TW-1:0] rr_tid
);

  typedef logic [N-1:0][TW-1:0] order_t;

  order_t       order_q, order_adj, order_nxt;
  logic [N-1:0] act_q, rise;

  function automatic order_t to_tail(input order_t o, input logic [TW-1:0] t);
    order_t r;
    logic   hit;
    r   = o;
    hit = 1'b0;
    for (int i = 0; i < N - 1; i++) begin
      if (o[i] == t) hit = 1'b1;
      if (hit) r[i] = o[i+1];
    end
    r[N-1] = t;
    return r;
  endfunction

  assign rise = thr_active & ~act_q;

  always_comb begin
    order_adj = order_q;
    for (int k = 0; k < N; k++) begin
      if (rise[k]) order_adj = to_tail(order_adj, TW'(k));
    end
    rr_vld = 1'b0;
    rr_tid = '0;
    for (int i = 0; i < N; i++) begin
      if (!rr_vld && cand[order_adj[i]]) begin
        rr_vld = 1'b1;
        rr_tid = order_adj[i];
      end
    end
    order_nxt = (en_move && rr_vld) ? to_tail(order_adj, rr_tid) : order_adj;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '1;
      for (int i = 0; i < N; i++) order_q[i] <= TW'(i);
    end else begin
      act_q   <= thr_active;
      order_q <= order_nxt;
    end
  end

endmodule

// File: rtl/fts_thread_sel.sv
module fts_thread_sel import fts_pkg::*; #(
  parameter  int N  = 4,
  parameter  int CW = 6,
  localparam int TW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           policy,
  input  logic [N*STATE_W-1:0] thr_state,
  input  logic [N-1:0]         thr_active,
  input  logic [N*CW-1:0]      iq_occ,
  input  logic [N*CW-1:0]      lsq_occ,
  output logic                 sel_vld,
  output logic [TW-1:0]        sel_tid
);

  fts_policy_e   pol;
  logic [N-1:0]  cand;
  logic          rr_vld, iq_vld, lsq_vld, solo_vld, nxt_vld;
  logic [TW-1:0] rr_tid, iq_tid, lsq_tid, solo_tid, nxt_tid;

  assign pol = fts_policy_e'(policy);

  fts_elig #(.N(N)) i_elig (
    .thr_state (thr_state),
    .thr_active(thr_active),
    .cand      (cand)
  );

  fts_rr_order #(.N(N), .TW(TW)) i_rr (
    .clk       (clk),
    .rst       (rst),
    .en_move   (pol == POL_ROTATE),
    .cand      (cand),
    .thr_active(thr_active),
    .rr_vld    (rr_vld),
    .rr_tid    (rr_tid)
  );

  fts_min_pick #(.N(N), .CW(CW), .TW(TW)) i_iq (
    .cand    (cand),
    .occ     (iq_occ),
    .pick_vld(iq_vld),
    .pick_tid(iq_tid)
  );

  fts_min_pick #(.N(N), .CW(CW), .TW(TW)) i_lsq (
    .cand    (cand),
    .occ     (lsq_occ),
    .pick_vld(lsq_vld),
    .pick_tid(lsq_tid)
  );

  always_comb begin
    logic seen;
    seen     = 1'b0;
    solo_vld = 1'b0;
    solo_tid = '0;
    for (int i = 0; i < N; i++) begin
      if (!seen && thr_active[i]) begin
        seen     = 1'b1;
        solo_tid = TW'(i);
        solo_vld = cand[i];
      end
    end
  end

  always_comb begin
    case (pol)
      POL_IQ:   begin nxt_vld = iq_vld;   nxt_tid = iq_tid;   end
      POL_LSQ:  begin nxt_vld = lsq_vld;  nxt_tid = lsq_tid;  end
      POL_SOLO: begin nxt_vld = solo_vld; nxt_tid = solo_tid; end
      default:  begin nxt_vld = rr_vld;   nxt_tid = rr_tid;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_vld <= 1'b0;
      sel_tid <= '0;
    end else begin
      sel_vld <= nxt_vld;
      sel_tid <= nxt_vld ? nxt_tid : '0;
    end
  end

endmodule

// File: rtl/fts_thread_sel_chk.sv
module fts_thread_sel_chk import fts_pkg::*; #(
  parameter  int N  = 4,
  parameter  int CW = 6,
  localparam int TW = (N > 1) ? $clog2(N) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           policy,
  input logic [N*STATE_W-1:0] thr_state,
  input logic [N-1:0]         thr_active,
  input logic [N*CW-1:0]      iq_occ,
  input logic [N*CW-1:0]      lsq_occ,
  input logic                 sel_vld,
  input logic [TW-1:0]        sel_tid
);

  logic            primed;
  logic [1:0]      pol_d;
  logic [N-1:0]    ok_d;
  logic [N*CW-1:0] iq_d, lsq_d;
  logic            iq_best, lsq_best;

  always_ff @(posedge clk) begin
    primed <= !rst;
    pol_d  <= policy;
    iq_d   <= iq_occ;
    lsq_d  <= lsq_occ;
    for (int i = 0; i < N; i++)
      ok_d[i] <= thr_active[i] && state_ok(thr_state[i*STATE_W +: STATE_W]);
  end

  always_comb begin
    iq_best  = 1'b1;
    lsq_best = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (ok_d[i]) begin
        if (iq_d[i*CW +: CW] < iq_d[sel_tid*CW +: CW] ||
            (iq_d[i*CW +: CW] == iq_d[sel_tid*CW +: CW] && TW'(i) < sel_tid))
          iq_best = 1'b0;
        if (lsq_d[i*CW +: CW] < lsq_d[sel_tid*CW +: CW] ||
            (lsq_d[i*CW +: CW] == lsq_d[sel_tid*CW +: CW] && TW'(i) < sel_tid))
          lsq_best = 1'b0;
      end
    end
  end

  // R1
  winner_is_candidate_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    sel_vld |-> ok_d[sel_tid]);

  // R8
  no_candidate_no_grant_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    (ok_d == '0) |-> !sel_vld);

  // R5
  iq_lowest_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    (sel_vld && pol_d == 2'd1) |-> iq_best);

  // R6
  lsq_lowest_chk: assert property (@(posedge clk) disable iff (rst || !primed)
    (sel_vld && pol_d == 2'd2) |-> lsq_best);

  // R7
  solo_one_active_chk: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'd3) |-> ($countones(thr_active) <= 1));

endmodule

bind fts_thread_sel fts_thread_sel_chk #(.N(N), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .policy(policy), .thr_state(thr_state),
  .thr_active(thr_active), .iq_occ(iq_occ), .lsq_occ(lsq_occ),
  .sel_vld(sel_vld), .sel_tid(sel_tid)
);

// File: tb/test_fts_thread_sel.sv
module test_fts_thread_sel;
  localparam int N  = 4;
  localparam int CW = 6;
  localparam int TW = 2;

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       policy;
  logic [N*3-1:0]   thr_state;
  logic [N-1:0]     thr_active;
  logic [N*CW-1:0]  iq_occ, lsq_occ;
  logic             sel_vld;
  logic [TW-1:0]    sel_tid;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic  vld;
    int    tid;
    string tag;
  } exp_t;
  exp_t sb[$];

  int          mlist [N];
  logic [N-1:0] mprev;

  always #10ns clk = ~clk;

  fts_thread_sel #(.N(N), .CW(CW)) i_fts_thread_sel (
    .clk(clk), .rst(rst), .policy(policy), .thr_state(thr_state),
    .thr_active(thr_active), .iq_occ(iq_occ), .lsq_occ(lsq_occ),
    .sel_vld(sel_vld), .sel_tid(sel_tid)
  );

  function automatic logic [N*3-1:0] st4(int a, int b, int c, int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  function automatic logic [N*CW-1:0] oc4(int a, int b, int c, int d);
    return {6'(d), 6'(c), 6'(b), 6'(a)};
  endfunction

  task automatic mv_tail(int t);
    int p;
    p = 0;
    for (int i = 0; i < N; i++) if (mlist[i] == t) p = i;
    for (int i = p; i < N - 1; i++) mlist[i] = mlist[i+1];
    mlist[N-1] = t;
  endtask

  // drive one cycle of inputs and queue the expected registered result
  task automatic step(string tag, int pol, logic [N*3-1:0] st, logic [N-1:0] act,
                      logic [N*CW-1:0] iq, logic [N*CW-1:0] lsq);
    exp_t         e;
    logic [N-1:0] cnd;
    policy = 2'(pol); thr_state = st; thr_active = act; iq_occ = iq; lsq_occ = lsq;
    for (int k = 0; k < N; k++) begin
      cnd[k] = act[k] && (st[k*3 +: 3] <= 3'd2);
      if (act[k] && !mprev[k]) mv_tail(k);
    end
    mprev = act;
    e.vld = 1'b0; e.tid = 0; e.tag = tag;
    if (pol == 0) begin
      for (int i = 0; i < N; i++)
        if (!e.vld && cnd[mlist[i]]) begin e.vld = 1'b1; e.tid = mlist[i]; end
      if (e.vld) mv_tail(e.tid);
    end else if (pol == 3) begin
      for (int i = N - 1; i >= 0; i--)
        if (act[i]) begin e.vld = cnd[i]; e.tid = i; end
    end else begin
      for (int i = 0; i < N; i++) begin
        int v, b;
        v = (pol == 1) ? int'(iq[i*CW +: CW]) : int'(lsq[i*CW +: CW]);
        b = (pol == 1) ? int'(iq[e.tid*CW +: CW]) : int'(lsq[e.tid*CW +: CW]);
        if (cnd[i] && (!e.vld || v < b)) begin e.vld = 1'b1; e.tid = i; end
      end
    end
    sb.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #5ns;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (sel_vld !== e.vld || (e.vld && int'(sel_tid) != e.tid)) begin
        n_bad++;
        $display("FAIL %s: got vld=%0b tid=%0d, expected vld=%0b tid=%0d",
                 e.tag, sel_vld, sel_tid, e.vld, e.tid);
      end
    end
  end

  initial begin
    #(20ns * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [N*3-1:0]  all_run;
    logic [N*CW-1:0] z;
    all_run = st4(0, 0, 0, 0);
    z = '0;
    for (int i = 0; i < N; i++) mlist[i] = i;
    mprev = '1;
    rst = 1'b1; policy = 2'd0; thr_state = all_run; thr_active = '1;
    iq_occ = z; lsq_occ = z;
    repeat (3) @(negedge clk);
    n_chk++;
    if (sel_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R3: got sel_vld=%0b, expected 0", sel_vld);
    end
    rst = 1'b0;
    // R3 R4: ascending start order, then rotation
    for (int k = 0; k < 5; k++) step("R4", 0, all_run, 4'hF, z, z);
    // R1: thread 1 waiting on a miss (code 4) is skipped, order stays
    for (int k = 0; k < 4; k++) step("R1", 0, st4(0, 4, 0, 0), 4'hF, z, z);
    // R8: only blocked codes
    step("R8", 0, st4(3, 5, 6, 7), 4'hF, z, z);
    // R1: codes 1 and 2 are eligible
    step("R1", 0, st4(1, 2, 7, 7), 4'hF, z, z);
    step("R1", 0, st4(1, 2, 7, 7), 4'hF, z, z);
    // R5: tie between threads 1 and 2 goes to 1
    step("R5", 1, all_run, 4'hF, oc4(5, 2, 2, 9), z);
    step("R5", 1, st4(0, 4, 0, 0), 4'hF, oc4(5, 2, 2, 9), z);
    step("R5", 1, all_run, 4'hF, oc4(0, 0, 0, 0), z);
    // R6: thread 3 inactive, thread 2 lowest
    step("R6", 2, all_run, 4'b0111, z, oc4(7, 7, 3, 0));
    step("R6", 2, all_run, 4'b0111, z, oc4(4, 1, 1, 0));
    // R10 R9: back to rotation, thread 3 rejoins at the tail
    for (int k = 0; k < 5; k++) step("R10", 0, all_run, 4'hF, z, z);
    // R9: thread 0 away then back
    step("R9", 0, all_run, 4'b1110, z, z);
    step("R9", 0, all_run, 4'b1110, z, z);
    for (int k = 0; k < 5; k++) step("R9", 0, all_run, 4'hF, z, z);
    // R7: single active thread
    step("R7", 3, all_run, 4'b0100, z, z);
    step("R7", 3, st4(0, 0, 6, 0), 4'b0100, z, z);
    step("R7", 3, all_run, 4'b0000, z, z);
    // R8: nobody active under rotation
    step("R8", 0, all_run, 4'b0000, z, z);
    // R9: all rejoin in index order
    for (int k = 0; k < 4; k++) step("R9", 0, all_run, 4'hF, z, z);
    // R2: result one cycle after each input change
    step("R2", 1, all_run, 4'hF, oc4(9, 9, 9, 1), z);
    step("R2", 1, all_run, 4'hF, oc4(1, 9, 9, 9), z);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule